// File: doc/BRIEF.md
# SAR ADC Serial Readout Controller

This block is the host side of a three-wire serial link to a successive-approximation converter. It owns chip select and the serial clock, and it reads the converter's data line. A frame opens when chip select falls, which also starts a conversion in the converter. The serial clock comes from the system clock through a divider that is set at run time. Over the frame the block shifts in a fixed number of bits: one leading zero, a 12-bit sample with the most significant bit first, and then trailing zeros. It then raises chip select again for an acquisition gap whose length is also set at run time.

The converter puts out the result of the conversion before the current one. For that reason the first sample after reset, or after the block leaves idle, has no real content, and the block flags it as stale. A frame whose leading bit or trailing bits are not zero still produces a result, but the result carries a framing-error flag. Frames start on a one-cycle start request, or back to back while free-run is held high. A start request that arrives while a frame or gap is in progress is remembered and served when the gap ends.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block goes to idle after that edge. In idle, cs_n_o is 1, sclk_o is 0, smp_valid_o is 0, smp_seq_o is 0 and smp_data_o is 0.
- R2: In idle, start_i or freerun_i high at an edge drives cs_n_o low after that edge, with sclk_o still 0.
- R3: Let H be div_i, read when the frame starts, with 0 taken as 1. sclk_o is low for H cycles and then high for H cycles, repeated FRAME_CYC times (14 by default). cs_n_o stays low for exactly 2·H·FRAME_CYC cycles.
- R4: sdo_i is sampled at each rising edge of sclk_o. Sample 1 is the leading bit. Samples 2 to 13 give smp_data_o[11] down to smp_data_o[0]. The remaining samples are trailing bits.
- R5: smp_valid_o is high for exactly one cycle, which is the first cycle with cs_n_o high after a frame. smp_data_o and the flags change only in that cycle.
- R6: cs_n_o stays high between frames for L cycles. L is the largest of acq_i·2·H, ACQ_MIN (4 by default) and 1, with acq_i read when the frame starts.
- R7: When the gap ends, another frame starts if freerun_i is high, if start_i is high, or if a start was requested during the previous frame or gap. Otherwise the block returns to idle.
- R8: smp_ferr_o is 1 when the leading bit or any trailing bit was 1. smp_data_o still carries the 12 data bits.
- R9: smp_stale_o is 1 for a sample whose frame began from idle, and 0 for a frame that followed a gap directly.
- R10: smp_seq_o inverts with every delivered sample.
- R11: If div_i or acq_i change during a frame or gap, the timing of that frame and gap does not change.
- R12: sdo_i has no effect while cs_n_o is high. A line held at 1 between frames raises no framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request for one frame |
| freerun_i | input | 1 | Run frames back to back while high |
| div_i | input | DIV_W | Serial clock half-period, in system clocks |
| acq_i | input | ACQ_W | Acquisition gap, in serial clock periods |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| sdo_i | input | 1 | Serial data from the converter |
| smp_valid_o | output | 1 | One-cycle pulse when a sample is delivered |
| smp_data_o | output | DATA_W | Delivered sample |
| smp_stale_o | output | 1 | Sample carries no valid earlier conversion |
| smp_ferr_o | output | 1 | Leading or trailing bits were not zero |
| smp_seq_o | output | 1 | Inverts with every delivered sample |

## Verification
Two pairs of events can fall on the same edge. The first is a start request on the edge where a frame ends and its sample is delivered. The second is a start request on the edge where the gap expires and the next frame must be launched. The bench counts cycles from a known launch and places one-cycle start pulses on each of these edges. Its cycle-level model then judges the outcome. In the first case the request must survive and produce exactly one extra frame. In the second it must launch the frame directly, with no idle cycle in between and with the stale flag low.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_ACQ   = 2'd2
    } rd_state_e;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } gen_t;

    gen_t gen_d, gen_q;
    logic wrap;

    always_comb begin
        gen_d = gen_q;
        wrap  = run_i && (gen_q.cnt == half_i - 1'b1);
        if (!run_i) begin
            gen_d.cnt  = '0;
            gen_d.sclk = 1'b0;
        end else if (wrap) begin
            gen_d.cnt  = '0;
            gen_d.sclk = ~gen_q.sclk;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sclk_o = gen_q.sclk;
    assign rise_o = wrap && !gen_q.sclk;
    assign fall_o = wrap && gen_q.sclk;

endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
    parameter int DATA_W    = 12,
    parameter int FRAME_CYC = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] data_o,
    output logic              bad_o
);

    localparam int TRAIL_W = FRAME_CYC - 1 - DATA_W;

    logic [FRAME_CYC-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (take_i) sh_d = {sh_q[FRAME_CYC-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign data_o = sh_q[FRAME_CYC-2 -: DATA_W];

    generate
        if (TRAIL_W > 0) begin : g_trail
            assign bad_o = sh_q[FRAME_CYC-1] | (|sh_q[TRAIL_W-1:0]);
        end else begin : g_lead_only
            assign bad_o = sh_q[FRAME_CYC-1];
        end
    endgenerate

endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
    import adc_rdout_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int FRAME_CYC = 14,
    parameter int DIV_W     = 8,
    parameter int ACQ_W     = 8,
    parameter int ACQ_MIN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              freerun_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [ACQ_W-1:0]  acq_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    input  logic              sdo_i,
    output logic              smp_valid_o,
    output logic [DATA_W-1:0] smp_data_o,
    output logic              smp_stale_o,
    output logic              smp_ferr_o,
    output logic              smp_seq_o
);

    localparam int BIT_W = $clog2(FRAME_CYC);
    localparam int LEN_W = ACQ_W + DIV_W + 1;

    typedef struct packed {
        rd_state_e         st;
        logic [BIT_W-1:0]  bcnt;
        logic [LEN_W-1:0]  acnt;
        logic [LEN_W-1:0]  alen;
        logic [DIV_W-1:0]  half;
        logic              pend;
        logic              first;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              stale;
        logic              ferr;
        logic              seq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              run, rise, fall, bad;
    logic [DATA_W-1:0] sh_data;
    logic [DIV_W-1:0]  half_new;
    logic [LEN_W-1:0]  len_raw, len_new;
    logic              go;

    assign run = (ctl_q.st == ST_FRAME);

    adc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .half_i (ctl_q.half),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    adc_shift_in #(.DATA_W(DATA_W), .FRAME_CYC(FRAME_CYC)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (rise),
        .bit_i  (sdo_i),
        .data_o (sh_data),
        .bad_o  (bad)
    );

    // Timing for the next frame and gap, taken from the inputs at launch.
    always_comb begin
        half_new = (div_i == '0) ? DIV_W'(1) : div_i;
        len_raw  = LEN_W'(acq_i) * LEN_W'(half_new) * LEN_W'(2);
        len_new  = (len_raw < LEN_W'(ACQ_MIN)) ? LEN_W'(ACQ_MIN) : len_raw;
        if (len_new == '0) len_new = LEN_W'(1);
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        go          = 1'b0;
        case (ctl_q.st)
            ST_IDLE: go = start_i | freerun_i;
            ST_FRAME: begin
                if (start_i) ctl_d.pend = 1'b1;
                if (fall && ctl_q.bcnt == BIT_W'(FRAME_CYC - 1)) begin
                    ctl_d.st    = ST_ACQ;
                    ctl_d.acnt  = '0;
                    ctl_d.valid = 1'b1;
                    ctl_d.data  = sh_data;
                    ctl_d.ferr  = bad;
                    ctl_d.stale = ctl_q.first;
                    ctl_d.seq   = ~ctl_q.seq;
                end else if (fall) begin
                    ctl_d.bcnt = ctl_q.bcnt + 1'b1;
                end
            end
            ST_ACQ: begin
                if (start_i) ctl_d.pend = 1'b1;
                if (ctl_q.acnt == ctl_q.alen - 1'b1) begin
                    if (freerun_i || ctl_d.pend) go = 1'b1;
                    else                         ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.acnt = ctl_q.acnt + 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (go) begin
            ctl_d.st    = ST_FRAME;
            ctl_d.bcnt  = '0;
            ctl_d.half  = half_new;
            ctl_d.alen  = len_new;
            ctl_d.pend  = 1'b0;
            ctl_d.first = (ctl_q.st == ST_IDLE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cs_n_o      = (ctl_q.st != ST_FRAME);
    assign smp_valid_o = ctl_q.valid;
    assign smp_data_o  = ctl_q.data;
    assign smp_stale_o = ctl_q.stale;
    assign smp_ferr_o  = ctl_q.ferr;
    assign smp_seq_o   = ctl_q.seq;

endmodule

// File: rtl/adc_rdout_chk.sv
module adc_rdout_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_o,
    input logic              sclk_o,
    input logic              smp_valid_o,
    input logic [DATA_W-1:0] smp_data_o,
    input logic              smp_seq_o
);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (cs_n_o && !sclk_o && !smp_valid_o && !smp_seq_o));

    p_sclk_low_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |=> !smp_valid_o);

    p_valid_at_cs_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> smp_valid_o);

    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_o |-> $stable(smp_data_o));

    p_seq_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> (smp_seq_o != $past(smp_seq_o)));

endmodule

bind adc_rdout_ctrl adc_rdout_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .smp_valid_o (smp_valid_o),
    .smp_data_o  (smp_data_o),
    .smp_seq_o   (smp_seq_o)
);

// File: tb/adc_rdout_ctrl_bench.sv
`timescale 1ns/1ps
module adc_rdout_ctrl_bench;

    localparam int FRM  = 14;
    localparam int AMIN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        freerun = 1'b0;
    logic [7:0]  div = 8'd2;
    logic [7:0]  acq = 8'd1;
    logic        sdo = 1'b1;
    logic        cs_n, sclk, valid, stale, ferr, seq;
    logic [11:0] data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_rdout_ctrl #(.DATA_W(12), .FRAME_CYC(FRM), .DIV_W(8), .ACQ_W(8), .ACQ_MIN(AMIN)) u_adc_rdout_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .freerun_i(freerun),
        .div_i(div), .acq_i(acq), .cs_n_o(cs_n), .sclk_o(sclk), .sdo_i(sdo),
        .smp_valid_o(valid), .smp_data_o(data), .smp_stale_o(stale),
        .smp_ferr_o(ferr), .smp_seq_o(seq)
    );

    // Converter model: returns the previous conversion, one bit per falling edge
    int         slv_n = 0;
    logic [11:0] slv_hold = 12'h3C5;
    logic [11:0] slv_word = 12'h000;
    bit         inj_lead = 1'b0, inj_trail = 1'b0;
    bit         slv_lead_bad = 1'b0, slv_trail_bad = 1'b0;
    int         bidx = 0;

    always @(negedge cs_n) begin
        slv_word      = slv_hold;
        slv_hold      = 12'((slv_n * 1117 + 613) ^ (slv_n << 6));
        slv_n++;
        slv_lead_bad  = inj_lead;
        slv_trail_bad = inj_trail;
        bidx          = 0;
        sdo           = slv_lead_bad;
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            bidx++;
            if (bidx <= 12) sdo = slv_word[12 - bidx];
            else            sdo = slv_trail_bad;
        end
    end

    always @(posedge cs_n) sdo = 1'b1;   // line pulled high between frames (R12)

    // Cycle-level reference model
    int   r_mode = 0, r_t = 0, r_a = 0, r_h = 1, r_l = 1;
    bit   r_pend = 0, r_first = 0, r_seq = 0, ref_live = 0;
    bit   e_cs = 1, e_sclk = 0, e_valid = 0, e_stale = 0, e_ferr = 0;
    int   e_data = 0;

    task automatic ref_launch(input bit from_idle);
        int tmp;
        r_mode  = 1;
        r_t     = 0;
        e_cs    = 0;
        e_sclk  = 0;
        r_h     = (div == 0) ? 1 : int'(div);
        tmp     = int'(acq) * 2 * r_h;
        if (tmp < AMIN) tmp = AMIN;
        if (tmp < 1) tmp = 1;
        r_l     = tmp;
        r_first = from_idle;
        r_pend  = 0;
    endtask

    always @(posedge clk) begin
        ref_live = 1;
        if (!rst_n) begin
            r_mode = 0; r_pend = 0; r_seq = 0; r_first = 0;
            e_cs = 1; e_sclk = 0; e_valid = 0; e_data = 0; e_stale = 0; e_ferr = 0;
        end else begin
            e_valid = 0;
            case (r_mode)
                0: if (start || freerun) ref_launch(1);
                1: begin
                    if (start) r_pend = 1;
                    r_t++;
                    if (r_t == 2 * r_h * FRM) begin
                        e_cs = 1; e_sclk = 0; e_valid = 1;
                        e_data  = int'(slv_word);
                        e_ferr  = slv_lead_bad | slv_trail_bad;
                        e_stale = r_first;
                        r_seq   = !r_seq;
                        r_mode  = 2;
                        r_a     = 0;
                    end else begin
                        e_sclk = ((r_t / r_h) % 2) == 1;
                    end
                end
                default: begin
                    if (start) r_pend = 1;
                    r_a++;
                    if (r_a == r_l) begin
                        if (freerun || r_pend) ref_launch(0);
                        else r_mode = 0;
                    end
                end
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (ref_live && !done) begin
            chk("R2 R3 R6 R7 R11 cs_n", int'(cs_n), int'(e_cs));
            chk("R3 sclk", int'(sclk), int'(e_sclk));
            chk("R5 valid", int'(valid), int'(e_valid));
            chk("R4 data", int'(data), e_data);
            chk("R9 stale", int'(stale), int'(e_stale));
            chk("R8 R12 ferr", int'(ferr), int'(e_ferr));
            chk("R10 seq", int'(seq), int'(r_seq));
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (valid) break;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc == 150000 && !done) begin
                done = 1'b1;
                n_fail++;
                $display("FAIL watchdog: run did not finish, actual=%0d expected<150000 cycles", cyc);
                summary();
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: idle state under reset
        chk("R1 cs_n reset", int'(cs_n), 1);
        chk("R1 sclk reset", int'(sclk), 0);
        chk("R1 valid reset", int'(valid), 0);
        chk("R1 seq reset", int'(seq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Single frame from idle: stale sample (R2, R9)
        pulse_start();
        wait_valid();
        repeat (12) @(negedge clk);

        // Start from idle, then a request on the exact frame-end edge (R7)
        pulse_start();
        repeat (2 * 2 * FRM - 1) @(negedge clk);
        pulse_start();
        wait_valid();
        wait_valid();
        repeat (12) @(negedge clk);

        // Framing errors still deliver data (R8)
        inj_lead = 1'b1;
        pulse_start();
        wait_valid();
        inj_lead = 1'b0;
        repeat (8) @(negedge clk);
        inj_trail = 1'b1;
        pulse_start();
        wait_valid();
        inj_trail = 1'b0;
        repeat (8) @(negedge clk);

        // Request on the edge where the gap expires: direct launch, not stale
        div = 8'd1; acq = 8'd0;
        pulse_start();
        wait_valid();
        repeat (AMIN - 1) @(negedge clk);
        pulse_start();
        wait_valid();
        repeat (10) @(negedge clk);

        // Free-run with mid-frame changes of timing (R7, R11)
        freerun = 1'b1;
        repeat (10) @(negedge clk);
        div = 8'd3; acq = 8'd5;
        wait_valid();
        wait_valid();
        div = 8'd0; acq = 8'd2;
        repeat (5) @(negedge clk);
        wait_valid();
        wait_valid();
        freerun = 1'b0;
        wait_valid();
        repeat (40) @(negedge clk);

        // Divider of zero behaves as one (R3)
        div = 8'd0; acq = 8'd0;
        pulse_start();
        wait_valid();
        repeat (10) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule